// File: doc/BRIEF.md
# Programmable Pin Cell with Gray-Selected 4:1 Mux

This block is the logic of a single programmable pin. Four words arrive from the routing fabric, and a two-bit select picks one of them at run time. The select uses a Gray-style code, so moving between neighbouring inputs changes only one select bit. One storage element sits inside the cell. Static configuration bits make it an edge-triggered flip-flop or a level-sensitive latch.

The same storage element can be steered into one of two places. In the outbound path it registers the mux result on its way to the pin. In the inbound path it registers the pin value on its way back to the fabric. Further configuration bits choose:
- a combinational bypass of the outbound storage,
- the active clock level or edge,
- the polarity of the value driven to the pin.

The output enable is forwarded without change. An asynchronous global reset clears the stored value.

Top module: `pin_cell`

## Requirements
- R1: The select `mux_sel` picks route slot A (bits W-1:0 of `route_in`) for code 2'b00, slot B (next W bits) for 2'b01, slot C for 2'b11 and slot D (top W bits) for 2'b10.
- R2: With `cfg_latch`=0, the storage element loads its data on each rising edge of the effective clock and holds it between edges; in the outbound path (`cfg_path_in`=0, `cfg_bypass`=0) it drives `pad_out`.
- R3: With `cfg_latch`=1, the storage element follows its data while the effective clock is high and holds while it is low.
- R4: The effective clock equals `cell_clk` when `cfg_clk_inv`=0 and its inverse when `cfg_clk_inv`=1.
- R5: With `cfg_path_in`=0 and `cfg_bypass`=1, `pad_out` follows the mux result combinationally.
- R6: `cfg_out_inv`=1 inverts every bit of `pad_out` in every mode.
- R7: With `cfg_path_in`=1, the storage element takes `pad_in` as its data and `fab_out` shows the stored value.
- R8: With `cfg_path_in`=1, `pad_out` is the mux result passed combinationally through the output polarity.
- R9: With `cfg_path_in`=0, `fab_out` equals `pad_in` unregistered.
- R10: `rst_glb` high clears the stored value to 0 at once, without waiting for a clock edge.
- R11: `pad_oe` equals `oe_in` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cell_clk | input | 1 | Clock of the storage element before polarity selection |
| rst_glb | input | 1 | Asynchronous global reset, active high |
| cfg_latch | input | 1 | 1 selects latch, 0 selects flip-flop |
| cfg_path_in | input | 1 | 1 places storage in the inbound path, 0 in the outbound path |
| cfg_bypass | input | 1 | 1 makes the outbound path combinational |
| cfg_clk_inv | input | 1 | 1 inverts the storage clock |
| cfg_out_inv | input | 1 | 1 inverts the pin output |
| mux_sel | input | 2 | Gray-coded dynamic select |
| route_in | input | 4*W | Four routed data words, slot A in the low bits |
| pad_in | input | W | Value arriving from the pin |
| oe_in | input | 1 | Output enable request |
| pad_out | output | W | Value driven toward the pin |
| pad_oe | output | 1 | Output enable toward the pin |
| fab_out | output | W | Value returned to the routing fabric |

## Verification
The hardest case to reach is the shared storage element under a clock polarity or element-type change. Such a change can produce an edge or a transparent window that the element will act on. The stimulus makes each change at a clock phase where the effective clock only falls. It then checks the held value in the half-period before the next active phase, and checks the newly captured value just after that phase opens. In the inbound path the stored value is visible only on `fab_out`. So that case is driven through a new `pad_in` value, and the check confirms that the old value persists until the effective edge arrives.

// File: rtl/pin_cell_pkg.sv
package pin_cell_pkg;

  // Dynamic select codes: neighbouring inputs differ in one bit
  typedef enum logic [1:0] {
    SEL_A = 2'b00,
    SEL_B = 2'b01,
    SEL_C = 2'b11,
    SEL_D = 2'b10
  } sel_code_e;

  localparam int unsigned NUM_SLOTS = 4;

  // Convert a Gray select code into the slot index of route_in
  function automatic logic [1:0] gray_to_slot(input logic [1:0] code);
    return {code[1], code[1] ^ code[0]};
  endfunction

endpackage

// File: rtl/pin_mux4.sv
module pin_mux4 #(
  parameter int unsigned W = 4
) (
  input  logic [pin_cell_pkg::NUM_SLOTS*W-1:0] route,
  input  logic [1:0]                           sel,
  output logic [W-1:0]                         pick
);
  import pin_cell_pkg::*;

  logic [W-1:0] slot [NUM_SLOTS];
  logic [1:0]   slot_idx;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot[g] = route[g*W +: W];
  end

  assign slot_idx = gray_to_slot(sel);
  assign pick     = slot[slot_idx];

endmodule

// File: rtl/pin_store.sv
module pin_store #(
  parameter int unsigned W = 4
) (
  input  logic         clk_eff,
  input  logic         rst,
  input  logic         latch_mode,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] ff_q;
  logic [W-1:0] lat_q;

  // Edge-triggered variant
  always_ff @(posedge clk_eff or posedge rst) begin
    if (rst) ff_q <= '0;
    else     ff_q <= d;
  end

  // Level-sensitive variant, open while the effective clock is high
  always_latch begin
    if (rst)          lat_q = '0;
    else if (clk_eff) lat_q = d;
  end

  assign q = latch_mode ? lat_q : ff_q;

  // R2
  ff_capture_chk: assert property (@(posedge clk_eff) disable iff (rst)
    (!latch_mode && $past(!latch_mode) && $past(!rst)) |-> q == $past(d));

  // R3
  latch_follow_chk: assert property (@(negedge clk_eff) disable iff (rst)
    latch_mode |-> q == d);

endmodule

// File: rtl/pin_steer.sv
module pin_steer #(
  parameter int unsigned W = 4
) (
  input  logic         path_in,
  input  logic         bypass,
  input  logic         out_inv,
  input  logic [W-1:0] mux_o,
  input  logic [W-1:0] store_q,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] store_d,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] fab_out
);

  logic         comb_out;
  logic [W-1:0] out_raw;

  assign comb_out = path_in | bypass;
  assign store_d  = path_in ? pad_in : mux_o;
  assign out_raw  = comb_out ? mux_o : store_q;
  assign pad_out  = out_raw ^ {W{out_inv}};
  assign fab_out  = path_in ? store_q : pad_in;

endmodule

// File: rtl/pin_cell.sv
module pin_cell #(
  parameter int unsigned W = 4
) (
  input  logic           cell_clk,
  input  logic           rst_glb,
  input  logic           cfg_latch,
  input  logic           cfg_path_in,
  input  logic           cfg_bypass,
  input  logic           cfg_clk_inv,
  input  logic           cfg_out_inv,
  input  logic [1:0]     mux_sel,
  input  logic [4*W-1:0] route_in,
  input  logic [W-1:0]   pad_in,
  input  logic           oe_in,
  output logic [W-1:0]   pad_out,
  output logic           pad_oe,
  output logic [W-1:0]   fab_out
);
  import pin_cell_pkg::*;

  logic         clk_eff;
  logic [W-1:0] mux_o;
  logic [W-1:0] store_d;
  logic [W-1:0] store_q;

  assign clk_eff = cell_clk ^ cfg_clk_inv;
  assign pad_oe  = oe_in;

  pin_mux4 #(.W(W)) u_mux (
    .route (route_in),
    .sel   (mux_sel),
    .pick  (mux_o)
  );

  pin_store #(.W(W)) u_store (
    .clk_eff    (clk_eff),
    .rst        (rst_glb),
    .latch_mode (cfg_latch),
    .d          (store_d),
    .q          (store_q)
  );

  pin_steer #(.W(W)) u_steer (
    .path_in (cfg_path_in),
    .bypass  (cfg_bypass),
    .out_inv (cfg_out_inv),
    .mux_o   (mux_o),
    .store_q (store_q),
    .pad_in  (pad_in),
    .store_d (store_d),
    .pad_out (pad_out),
    .fab_out (fab_out)
  );

  // Independent view of the selected slot for checking
  logic [W-1:0] chk_pick;
  always_comb begin
    case (sel_code_e'(mux_sel))
      SEL_A:   chk_pick = route_in[0*W +: W];
      SEL_B:   chk_pick = route_in[1*W +: W];
      SEL_C:   chk_pick = route_in[2*W +: W];
      default: chk_pick = route_in[3*W +: W];
    endcase
  end

  // R10
  rst_clear_chk: assert property (@(posedge cell_clk)
    ($past(rst_glb) && rst_glb) |-> store_q == '0);

  // R8
  pathb_out_chk: assert property (@(posedge cell_clk) disable iff (rst_glb)
    cfg_path_in |-> pad_out == (cfg_out_inv ? ~chk_pick : chk_pick));

  // R9
  patha_fab_chk: assert property (@(posedge cell_clk) disable iff (rst_glb)
    !cfg_path_in |-> fab_out == pad_in);

endmodule

// File: tb/pin_cell_bench.sv
module pin_cell_bench;
  localparam int W = 4;

  logic           cell_clk = 1'b0;
  logic           rst_glb;
  logic           cfg_latch, cfg_path_in, cfg_bypass, cfg_clk_inv, cfg_out_inv;
  logic [1:0]     mux_sel;
  logic [4*W-1:0] route_in;
  logic [W-1:0]   pad_in;
  logic           oe_in;
  logic [W-1:0]   pad_out;
  logic           pad_oe;
  logic [W-1:0]   fab_out;

  always #10 cell_clk = ~cell_clk;

  pin_cell #(.W(W)) u_pin_cell (
    .cell_clk    (cell_clk),
    .rst_glb     (rst_glb),
    .cfg_latch   (cfg_latch),
    .cfg_path_in (cfg_path_in),
    .cfg_bypass  (cfg_bypass),
    .cfg_clk_inv (cfg_clk_inv),
    .cfg_out_inv (cfg_out_inv),
    .mux_sel     (mux_sel),
    .route_in    (route_in),
    .pad_in      (pad_in),
    .oe_in       (oe_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .fab_out     (fab_out)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] eo;
    logic [W-1:0] ef;
    logic         chk_fab;
    logic         eoe;
  } exp_t;

  exp_t sb_q[$];
  event mon_ev;
  int   n_vec  = 0;
  int   n_miss = 0;
  bit   done   = 0;

  // Bench view of the route words: slot A=1, B=2, C=4, D=8
  function automatic logic [W-1:0] slot_val(input logic [1:0] code);
    logic [1:0] idx;
    idx = {code[1], code[0] ^ code[1]};
    return W'(1 << idx);
  endfunction

  task automatic expect_out(input string tag, input logic [W-1:0] eo,
                            input logic [W-1:0] ef, input logic chk_fab,
                            input logic eoe);
    exp_t it;
    it.tag = tag; it.eo = eo; it.ef = ef; it.chk_fab = chk_fab; it.eoe = eoe;
    sb_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic at_neg();
    @(negedge cell_clk); #3;
  endtask

  task automatic at_pos();
    @(posedge cell_clk); #3;
  endtask

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (pad_out !== it.eo) begin
          n_miss++;
          $display("FAIL %s pad_out actual=%h expected=%h", it.tag, pad_out, it.eo);
        end
        if (it.chk_fab && fab_out !== it.ef) begin
          n_miss++;
          $display("FAIL %s fab_out actual=%h expected=%h", it.tag, fab_out, it.ef);
        end
        if (pad_oe !== it.eoe) begin
          n_miss++;
          $display("FAIL %s pad_oe actual=%b expected=%b", it.tag, pad_oe, it.eoe);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst_glb = 1'b1; cfg_latch = 0; cfg_path_in = 0; cfg_bypass = 0;
    cfg_clk_inv = 0; cfg_out_inv = 0; mux_sel = 2'b00;
    route_in = {4'h8, 4'h4, 4'h2, 4'h1};
    pad_in = 4'h5; oe_in = 1'b0;

    // Reset state: R10 stored 0, R9 feedback raw, R11 oe
    at_pos();
    expect_out("R10 reset clears", 4'h0, 4'h5, 1, 0);

    // R1/R5 bypass through every select code, R11 oe high
    at_neg(); rst_glb = 0; cfg_bypass = 1; oe_in = 1;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] code;
      code = (c == 0) ? 2'b00 : (c == 1) ? 2'b01 : (c == 2) ? 2'b11 : 2'b10;
      mux_sel = code; #1;
      expect_out("R1 R5 R9 R11 gray select bypass", slot_val(code), 4'h5, 1, 1);
    end
    // R6 polarity in bypass, code 11 -> C
    at_neg(); cfg_out_inv = 1; mux_sel = 2'b11; #1;
    expect_out("R6 inverted bypass", ~4'h4, 4'h5, 1, 1);

    // R2 flip-flop in outbound path; last capture had code 11 -> 4
    at_neg(); cfg_out_inv = 0; cfg_bypass = 0; mux_sel = 2'b00; #1;
    expect_out("R2 ff holds before edge", 4'h4, 4'h5, 1, 1);
    at_pos();
    expect_out("R2 ff captures slot A", 4'h1, 4'h5, 1, 1);
    at_neg(); mux_sel = 2'b01; #1;
    expect_out("R2 ff hold", 4'h1, 4'h5, 1, 1);
    at_pos();
    expect_out("R2 ff captures slot B", 4'h2, 4'h5, 1, 1);

    // R4 inverted clock: change while clk high (effective clock falls)
    cfg_clk_inv = 1; mux_sel = 2'b11; #1;
    expect_out("R4 no capture on rising cell_clk", 4'h2, 4'h5, 1, 1);
    at_neg();
    expect_out("R4 capture on falling cell_clk", 4'h4, 4'h5, 1, 1);
    cfg_out_inv = 1; #1;
    expect_out("R6 inverted registered output", ~4'h4, 4'h5, 1, 1);
    cfg_out_inv = 0;

    // R3 latch, effective clock = inverted cell_clk
    at_pos(); cfg_latch = 1; mux_sel = 2'b10; #1;
    expect_out("R3 latch holds while closed", 4'h4, 4'h5, 1, 1);
    at_neg();
    expect_out("R3 latch passes slot D", 4'h8, 4'h5, 1, 1);
    mux_sel = 2'b00; #1;
    expect_out("R3 latch follows slot A", 4'h1, 4'h5, 1, 1);
    at_pos(); mux_sel = 2'b01; #1;
    expect_out("R3 latch holds after close", 4'h1, 4'h5, 1, 1);

    // R7/R8 inbound path with flip-flop
    at_neg(); cfg_latch = 0; cfg_path_in = 1; pad_in = 4'h9; #1;
    expect_out("R8 comb output in inbound path", 4'h2, 4'h0, 0, 1);
    at_neg();
    expect_out("R7 captured pad_in", 4'h2, 4'h9, 1, 1);
    pad_in = 4'h6; cfg_out_inv = 1; #1;
    expect_out("R7 R8 R6 hold and inverted output", ~4'h2, 4'h9, 1, 1);
    at_neg();
    expect_out("R7 captured new pad_in", ~4'h2, 4'h6, 1, 1);

    // R10 asynchronous reset mid-phase
    rst_glb = 1; #1;
    expect_out("R10 async clear", ~4'h2, 4'h0, 1, 1);
    cfg_latch = 1; #1;
    expect_out("R10 latch cleared", ~4'h2, 4'h0, 1, 1);
    oe_in = 0; #1;
    expect_out("R11 oe follows", ~4'h2, 4'h0, 1, 0);
    at_pos(); rst_glb = 0;
    at_pos();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule